// File: doc/BRIEF.md
# DDR Write Burst Packer

This block sits behind the data pins of a double-data-rate memory write path. In every clock cycle it receives a pair of data beats: one captured on the rising strobe edge and one on the falling edge. Each beat carries N data bits and one mask bit for each byte lane. A write burst is eight beats, which is four accepted cycles. The block collects the burst into a single 8N-bit word and builds a matching per-byte write-enable vector. It then hands both to the memory core in one cycle, together with the burst's start column.

A burst is opened by a one-cycle start pulse that carries the start column. Beat pairs are accepted only while a burst is open and the pair-valid input is high, so the sender may pause between pairs. A start pulse in the cycle that completes a burst opens the next burst at once, so back-to-back bursts lose no beat. The lane width N is a parameter and may be 16 or 32 bits.

Top module: `ddr_wr_burst_packer`

## Requirements
- R1: With N = LANE_W, the eight beats of a burst appear in core_wr_data with beat b at bits [b*N +: N]. Beat 0 is in the least-significant N bits and beat 7 in the most-significant.
- R2: In an accepted cycle the rising-edge beat (rise_data) is beat 2k and the falling-edge beat (fall_data) is beat 2k+1, where k counts accepted cycles from 0. The fourth accepted cycle completes the burst.
- R3: Mask bit l of a beat covers bits [8l+7:8l] of that beat. A mask bit of 1 means the byte must not be written: core_wr_be bit (b*N/8 + l) is 0 when beat b's mask bit l is 1, and 1 when it is 0.
- R4: rise_mask travels with rise_data and fall_mask travels with fall_data. The two masks of one cycle therefore control different bytes of the word.
- R5: A beat pair is ignored while no burst is open. Within a burst, a cycle with pair_valid low does not advance the beat count, and its data and mask have no effect on the word.
- R6: core_wr_valid is high for exactly one cycle: the cycle after the clock edge that captures the fourth pair. core_wr_data, core_wr_be and core_wr_col keep their values until the next burst completes.
- R7: core_wr_col equals the start column given with wr_start, with bit 0 forced to 0.
- R8: A wr_start in the completing cycle of a burst opens the next burst, whose first pair may arrive in the next cycle. A wr_start while a burst is open and not completing is ignored: it changes neither the column nor the beat count.
- R9: A synchronous active-low reset closes any open burst, clears the beat count and clears core_wr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_start | input | 1 | One-cycle pulse that opens a write burst |
| wr_col | input | COL_W | Start column, sampled together with wr_start |
| pair_valid | input | 1 | The rising/falling beat pair in this cycle is valid |
| rise_data | input | LANE_W | Beat captured on the rising strobe edge |
| rise_mask | input | LANE_W/8 | Per-byte mask for rise_data, 1 = do not write |
| fall_data | input | LANE_W | Beat captured on the falling strobe edge |
| fall_mask | input | LANE_W/8 | Per-byte mask for fall_data, 1 = do not write |
| core_wr_valid | output | 1 | One-cycle strobe for the core write |
| core_wr_data | output | 8*LANE_W | Assembled burst word |
| core_wr_be | output | LANE_W | Per-byte write enables, 1 = write |
| core_wr_col | output | COL_W | Even-aligned start column of the burst |

## Verification
Random beats and masks, with random pauses between pairs, show whether each beat lands in its slot and whether idle cycles are kept out of the count. Directed bursts use an all-set mask and an all-clear mask to tell an inverted enable apart from a lane that is swapped or tied. An odd start column shows that bit 0 is dropped. Pairs offered while no burst is open, a start pulse in the middle of a burst, a start pulse chained into the completing cycle, and a reset in the middle of a burst separate the correct beat counting from counting that is shifted, restarted or dropped.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
   // eight beats per burst, two beats per clock cycle
   localparam int BEATS  = 8;
   localparam int PAIRS  = BEATS / 2;
   localparam int SLOT_W = $clog2(PAIRS);
endpackage

// File: rtl/wbp_burst_ctrl.sv
module wbp_burst_ctrl
   import wbp_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [COL_W-1:0]  wr_col,
   input  logic              pair_valid,
   output logic              take_pair,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              burst_done,
   output logic [COL_W-1:0]  burst_col
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAIRS - 1);
   localparam logic [COL_W-1:0]  EVEN_MASK = ~COL_W'(1);

   logic              active_q;
   logic [SLOT_W-1:0] cnt_q;
   logic [COL_W-1:0]  col_q;
   logic              start_ok;

   assign take_pair  = active_q & pair_valid;
   assign burst_done = take_pair & (cnt_q == LAST_SLOT);
   assign start_ok   = wr_start & (~active_q | burst_done);
   assign slot_idx   = cnt_q;
   assign burst_col  = col_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         col_q    <= '0;
      end else if (start_ok) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         col_q    <= wr_col & EVEN_MASK;
      end else if (burst_done) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (take_pair) begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !wr_start) |=> (!active_q && cnt_q == '0));

   // R2
   pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_pair && cnt_q != LAST_SLOT) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));

   // R8
   chain_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_done && wr_start) |=> (active_q && cnt_q == '0));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!active_q && cnt_q == '0));
endmodule

// File: rtl/wbp_pair_slots.sv
module wbp_pair_slots
   import wbp_pkg::*;
#(
   parameter int LANE_W = 16
) (
   input  logic                          clk,
   input  logic                          take_pair,
   input  logic [SLOT_W-1:0]             slot_idx,
   input  logic [LANE_W-1:0]             rise_data,
   input  logic [LANE_W/8-1:0]           rise_mask,
   input  logic [LANE_W-1:0]             fall_data,
   input  logic [LANE_W/8-1:0]           fall_mask,
   output logic [(PAIRS-1)*2*LANE_W-1:0] slot_data,
   output logic [(PAIRS-1)*LANE_W/4-1:0] slot_mask
);
   localparam int LANES = LANE_W / 8;

   // the last pair is never stored: it goes straight to the output register
   for (genvar k = 0; k < PAIRS - 1; k++) begin : g_slot
      logic [2*LANE_W-1:0] d_q;
      logic [2*LANES-1:0]  m_q;
      always_ff @(posedge clk) begin
         if (take_pair && slot_idx == SLOT_W'(k)) begin
            d_q <= {fall_data, rise_data};
            m_q <= {fall_mask, rise_mask};
         end
      end
      assign slot_data[k*2*LANE_W +: 2*LANE_W] = d_q;
      assign slot_mask[k*2*LANES +: 2*LANES]   = m_q;
   end
endmodule

// File: rtl/ddr_wr_burst_packer.sv
module ddr_wr_burst_packer
   import wbp_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int COL_W  = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_start,
   input  logic [COL_W-1:0]         wr_col,
   input  logic                     pair_valid,
   input  logic [LANE_W-1:0]        rise_data,
   input  logic [LANE_W/8-1:0]      rise_mask,
   input  logic [LANE_W-1:0]        fall_data,
   input  logic [LANE_W/8-1:0]      fall_mask,
   output logic                     core_wr_valid,
   output logic [BEATS*LANE_W-1:0]  core_wr_data,
   output logic [LANE_W-1:0]        core_wr_be,
   output logic [COL_W-1:0]         core_wr_col
);
   localparam int LANES  = LANE_W / 8;
   localparam int WORD_W = BEATS * LANE_W;
   localparam int BE_W   = BEATS * LANES;

   if (!(LANE_W == 16 || LANE_W == 32)) begin : g_bad_lane
      $error("LANE_W must be 16 or 32");
   end
   if (COL_W < 2) begin : g_bad_col
      $error("COL_W must be at least 2");
   end

   logic                          take_pair;
   logic [SLOT_W-1:0]             slot_idx;
   logic                          burst_done;
   logic [COL_W-1:0]              burst_col;
   logic [(PAIRS-1)*2*LANE_W-1:0] slot_data;
   logic [(PAIRS-1)*2*LANES-1:0]  slot_mask;
   logic [WORD_W-1:0]             word_next;
   logic [BE_W-1:0]               mask_next;

   wbp_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start   (wr_start),
      .wr_col     (wr_col),
      .pair_valid (pair_valid),
      .take_pair  (take_pair),
      .slot_idx   (slot_idx),
      .burst_done (burst_done),
      .burst_col  (burst_col)
   );

   wbp_pair_slots #(.LANE_W(LANE_W)) u_slots (
      .clk       (clk),
      .take_pair (take_pair),
      .slot_idx  (slot_idx),
      .rise_data (rise_data),
      .rise_mask (rise_mask),
      .fall_data (fall_data),
      .fall_mask (fall_mask),
      .slot_data (slot_data),
      .slot_mask (slot_mask)
   );

   // stored pairs fill the low slots, the live pair fills the top slot
   for (genvar k = 0; k < PAIRS; k++) begin : g_word
      if (k < PAIRS - 1) begin : g_stored
         assign word_next[k*2*LANE_W +: 2*LANE_W] = slot_data[k*2*LANE_W +: 2*LANE_W];
         assign mask_next[k*2*LANES +: 2*LANES]   = slot_mask[k*2*LANES +: 2*LANES];
      end else begin : g_live
         assign word_next[k*2*LANE_W +: 2*LANE_W] = {fall_data, rise_data};
         assign mask_next[k*2*LANES +: 2*LANES]   = {fall_mask, rise_mask};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core_wr_valid <= 1'b0;
         core_wr_data  <= '0;
         core_wr_be    <= '0;
         core_wr_col   <= '0;
      end else begin
         core_wr_valid <= burst_done;
         if (burst_done) begin
            core_wr_data <= word_next;
            core_wr_be   <= ~mask_next;
            core_wr_col  <= burst_col;
         end
      end
   end

   // R6
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr_valid |=> !core_wr_valid);

   // R6
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_done |=> ($stable(core_wr_data) && $stable(core_wr_be) && $stable(core_wr_col)));

   // R7
   even_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr_valid |-> !core_wr_col[0]);
endmodule

// File: tb/tb_ddr_wr_burst_packer.sv
module tb_ddr_wr_burst_packer;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 16;
   localparam int L   = N / 8;
   localparam int W   = 8 * N;
   localparam int CW  = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_start = 1'b0;
   logic [CW-1:0] wr_col = '0;
   logic          pair_valid = 1'b0;
   logic [N-1:0]  rise_data = '0, fall_data = '0;
   logic [L-1:0]  rise_mask = '0, fall_mask = '0;
   logic          core_wr_valid;
   logic [W-1:0]  core_wr_data;
   logic [N-1:0]  core_wr_be;
   logic [CW-1:0] core_wr_col;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic          want_v = 1'b0;
   logic [W-1:0]  exp_word, last_word;
   logic [N-1:0]  exp_be;
   logic [CW-1:0] exp_col, cur_col;
   logic [31:0]   seed_sink;

   ddr_wr_burst_packer #(.LANE_W(N), .COL_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_col(wr_col),
      .pair_valid(pair_valid), .rise_data(rise_data), .rise_mask(rise_mask),
      .fall_data(fall_data), .fall_mask(fall_mask),
      .core_wr_valid(core_wr_valid), .core_wr_data(core_wr_data),
      .core_wr_be(core_wr_be), .core_wr_col(core_wr_col)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // a mask bit of 1 forbids the write, so the enable is its inverse
   function automatic logic [L-1:0] enables_of(input logic [L-1:0] m);
      return ~m;
   endfunction

   function automatic logic [CW-1:0] aligned(input logic [CW-1:0] c);
      logic [CW-1:0] r;
      r = c;
      r[0] = 1'b0;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // advance to the next falling edge and check the outputs expected there
   task automatic tick();
      @(negedge clk);
      chk(core_wr_valid == want_v, "R6 valid", W'(core_wr_valid), W'(want_v));
      if (want_v) begin
         chk(core_wr_data == exp_word, "R1/R2 data", core_wr_data, exp_word);
         chk(core_wr_be == exp_be, "R3/R4 byte enables", W'(core_wr_be), W'(exp_be));
         chk(core_wr_col == exp_col, "R7 column", W'(core_wr_col), W'(exp_col));
         last_word = exp_word;
         want_v = 1'b0;
      end
   endtask

   task automatic idle(input int n, input bit junk);
      for (int i = 0; i < n; i++) begin
         tick();
         wr_start   = 1'b0;
         pair_valid = junk;
         rise_data  = N'($urandom);
         fall_data  = N'($urandom);
         rise_mask  = L'($urandom);
         fall_mask  = L'($urandom);
      end
   endtask

   // mask_mode: 0 random, 1 all set, 2 all clear
   task automatic burst(input bit send_start, input logic [CW-1:0] col,
                        input bit chain, input logic [CW-1:0] next_col,
                        input int gap_pct, input bit mid_start, input int mask_mode);
      logic [W-1:0] ew;
      logic [N-1:0] eb;
      if (send_start) begin
         tick();
         wr_start   = 1'b1;
         wr_col     = col;
         pair_valid = 1'b0;
         cur_col    = col;
      end
      for (int k = 0; k < 4; k++) begin
         while (int'($urandom_range(99)) < gap_pct) begin
            tick();
            wr_start   = 1'b0;
            pair_valid = 1'b0;
            rise_data  = N'($urandom);
            fall_data  = N'($urandom);
            rise_mask  = L'($urandom);
            fall_mask  = L'($urandom);
         end
         tick();
         pair_valid = 1'b1;
         rise_data  = N'($urandom);
         fall_data  = N'($urandom);
         rise_mask  = (mask_mode == 1) ? '1 : (mask_mode == 2) ? '0 : L'($urandom);
         fall_mask  = (mask_mode == 1) ? '1 : (mask_mode == 2) ? '0 : L'($urandom);
         wr_start   = 1'b0;
         if (k == 3 && chain) begin
            wr_start = 1'b1;
            wr_col   = next_col;
         end else if (k == 1 && mid_start) begin
            wr_start = 1'b1;
            wr_col   = ~col;
         end
         ew[(2*k)*N +: N]   = rise_data;
         ew[(2*k+1)*N +: N] = fall_data;
         eb[(2*k)*L +: L]   = enables_of(rise_mask);
         eb[(2*k+1)*L +: L] = enables_of(fall_mask);
      end
      want_v   = 1'b1;
      exp_word = ew;
      exp_be   = eb;
      exp_col  = aligned(cur_col);
      if (chain) cur_col = next_col;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      seed_sink = $urandom(32'd20240611);
      cur_col = '0;
      // R9: reset state
      repeat (3) tick();
      chk(core_wr_valid == 1'b0, "R9 reset valid", W'(core_wr_valid), '0);
      rst_n = 1'b1;

      // R5: pairs offered with no open burst must not count
      idle(6, 1'b1);
      // R1 R2 R3 R7: basic burst, odd column
      burst(1'b1, 10'h0A5, 1'b0, '0, 0, 1'b0, 0);
      idle(3, 1'b0);
      // R6: outputs held after the strobe
      chk(core_wr_data == last_word, "R6 hold data", core_wr_data, last_word);

      // R3: all masked -> no byte enabled; none masked -> all enabled
      burst(1'b1, 10'h100, 1'b0, '0, 0, 1'b0, 1);
      idle(2, 1'b0);
      chk(core_wr_be == '0, "R3 all masked", W'(core_wr_be), '0);
      burst(1'b1, 10'h101, 1'b0, '0, 0, 1'b0, 2);
      idle(2, 1'b0);
      chk(core_wr_be == '1, "R3 none masked", W'(core_wr_be), W'({N{1'b1}}));

      // R5: pauses inside a burst
      burst(1'b1, 10'h3FF, 1'b0, '0, 50, 1'b0, 0);
      idle(2, 1'b1);

      // R8: start in the middle of a burst is ignored
      burst(1'b1, 10'h012, 1'b0, '0, 0, 1'b1, 0);
      idle(2, 1'b0);

      // R8: back-to-back chained bursts with no gap
      burst(1'b1, 10'h020, 1'b1, 10'h043, 0, 1'b0, 0);
      burst(1'b0, '0, 1'b1, 10'h067, 0, 1'b0, 0);
      burst(1'b0, '0, 1'b0, '0, 0, 1'b0, 0);
      idle(2, 1'b0);

      // R9: reset in the middle of a burst discards the partial beats
      tick();
      wr_start = 1'b1; wr_col = 10'h055; pair_valid = 1'b0;
      tick();
      wr_start = 1'b0; pair_valid = 1'b1;
      tick();
      tick();
      rst_n = 1'b0; pair_valid = 1'b0;
      tick();
      rst_n = 1'b1;
      idle(2, 1'b1);
      chk(core_wr_valid == 1'b0, "R9 no completion after reset", W'(core_wr_valid), '0);
      burst(1'b1, 10'h077, 1'b0, '0, 0, 1'b0, 0);
      idle(2, 1'b0);

      // random mix
      for (int i = 0; i < 60; i++) begin
         burst(1'b1, CW'($urandom), 1'b0, '0, int'($urandom_range(40)), 1'b0, 0);
         idle(int'($urandom_range(3)), 1'(($urandom_range(1))));
      end
      idle(3, 1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule